// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level tree of page tables held in memory. The top ten bits of the virtual address select an entry in the directory table, whose location is given by a table base register. That entry points at a leaf table, and the next ten bits select an entry there. The leaf entry supplies the physical page number, and the low twelve bits pass through unchanged as the byte offset within a 4 KB page. Each table holds 1024 four-byte entries, so every table fills exactly one page.

Requests arrive on a valid/ready handshake together with an access type (read or write). The walker issues one memory read per level over a simple request/response port whose latency may vary. It returns either the physical address or a fault code. A fault code tells apart a missing directory entry, a missing leaf entry and an access that the entry's permissions forbid. Only one walk is in flight at a time. A context-switch strobe loads a new table base, and the new value is used for every walk accepted after the load.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in progress. Once a request is accepted it stays low until the response has been taken (`rsp_valid` and `rsp_ready` high at the same edge), and it is high again in the following cycle.
- R2: The directory entry is read at address base + 4 × VA[31:22], using a full addition, so a base that is not page aligned carries into the upper bits.
- R3: The leaf entry is read at address {directory PPN, VA[21:12], 2'b00}.
- R4: An entry holds the physical page number in bits 31:12, a write-permission bit at bit 2, a read-permission bit at bit 1 and a present bit at bit 0.
- R5: A walk that succeeds returns `rsp_paddr` = {leaf PPN, VA[11:0]} with `rsp_fault` = 0.
- R6: A directory entry whose present bit is 0 ends the walk with `rsp_fault` = 1, and no leaf read is issued.
- R7: A leaf entry whose present bit is 0 gives `rsp_fault` = 2. The present check comes before the permission check, so a non-present entry with permission bits set still reports 2.
- R8: A read access needs the read bit and a write access needs the write bit. This is checked at both levels, and a failure gives `rsp_fault` = 3. A failure at the directory level issues no leaf read.
- R9: Each level raises `mem_rd_req` for exactly one cycle and then waits, for any number of cycles, for `mem_rsp_valid`. A response that arrives while no read is outstanding is ignored.
- R10: The table base resets to 0. A `ctx_load` pulse loads `ctx_root`, and the new value is used by walks accepted after the load. A walk already in flight keeps the base it started with.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold steady.
- R12: After reset, `req_ready` = 1, `rsp_valid` = 0 and `mem_rd_req` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| ctx_load | input | 1 | Load a new table base |
| ctx_root | input | 32 | New table base address |
| mem_rd_req | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address (0 when faulted) |
| rsp_fault | output | 2 | 0 ok, 1 directory absent, 2 leaf absent, 3 permission |

## Verification
The hardest cases to reach from the ports are a base reload that lands while a walk is waiting on memory, and memory responses that arrive when no read is outstanding. The bench forks a reload pulse into the middle of a long-latency walk. It then checks that the directory address logged by its memory model still comes from the old base, and that the next walk uses the new, unaligned base, which forces a carry. The memory model can also inject a stray response while the walker is idle, after which the bench checks that the walker stayed idle and that the next walk issues exactly its expected reads.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_L1   = 2'd1,
        WALK_L2   = 2'd2,
        WALK_DONE = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_L1_ABSENT = 2'd1,
        FLT_L2_ABSENT = 2'd2,
        FLT_ACCESS    = 2'd3
    } walk_fault_e;

    localparam int PTE_PRESENT_BIT = 0;
    localparam int PTE_READ_BIT    = 1;
    localparam int PTE_WRITE_BIT   = 2;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int PA_W     = 32,
    parameter int IDX_W    = 10,
    parameter int OFF_W    = 12,
    parameter int ENT_LOG2 = 2
) (
    input  logic [IDX_W-1:0]       dir_idx,
    input  logic [IDX_W-1:0]       leaf_idx,
    input  logic [PA_W-1:0]        root,
    input  logic [PA_W-OFF_W-1:0]  table_ppn,
    output logic [PA_W-1:0]        l1_addr,
    output logic [PA_W-1:0]        l2_addr
);
    // R2: directory entry address uses a full add so an unaligned base carries
    assign l1_addr = root + (PA_W'(dir_idx) << ENT_LOG2);

    // R3: leaf entry address; when a table exactly fills a page the
    // index bits drop straight into the offset field
    generate
        if (IDX_W + ENT_LOG2 == OFF_W) begin : g_packed
            assign l2_addr = {table_ppn, leaf_idx, {ENT_LOG2{1'b0}}};
        end else begin : g_sum
            assign l2_addr = {table_ppn, {OFF_W{1'b0}}} + (PA_W'(leaf_idx) << ENT_LOG2);
        end
    endgenerate

endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check #(
    parameter int PTE_W = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12
) (
    input  logic [PTE_W-1:0]       entry,
    input  logic                   is_write,
    output logic                   present,
    output logic                   allowed,
    output logic [PA_W-OFF_W-1:0]  ppn
);
    import ptw_pkg::*;

    localparam int PPN_W = PA_W - OFF_W;

    logic unused_flag_bits;

    // R4: entry layout
    assign present = entry[PTE_PRESENT_BIT];
    assign allowed = is_write ? entry[PTE_WRITE_BIT] : entry[PTE_READ_BIT];
    assign ppn     = entry[PTE_W-1 -: PPN_W];

    assign unused_flag_bits = ^entry[OFF_W-1:PTE_WRITE_BIT+1];

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic                   req_write,
    input  logic [PA_W-1:0]        l1_addr,
    input  logic [PA_W-1:0]        l2_addr,
    input  logic                   ent_present,
    input  logic                   ent_allowed,
    input  logic [PA_W-OFF_W-1:0]  ent_ppn,
    output logic [VA_W-1:0]        held_va,
    output logic                   held_write,
    output logic                   mem_rd_req,
    output logic [PA_W-1:0]        mem_rd_addr,
    input  logic                   mem_rsp_valid,
    output logic                   rsp_valid,
    input  logic                   rsp_ready,
    output logic [PA_W-1:0]        rsp_paddr,
    output logic [1:0]             rsp_fault
);
    import ptw_pkg::*;

    typedef struct packed {
        walk_state_e      st;
        logic             sent;
        logic             wr;
        logic [VA_W-1:0]  va;
        logic [PA_W-1:0]  addr;
        logic [PA_W-1:0]  pa;
        walk_fault_e      flt;
    } walk_t;

    walk_t walk_d, walk_q;

    always_comb begin
        walk_d = walk_q;
        case (walk_q.st)
            WALK_IDLE: begin
                if (req_valid) begin
                    walk_d.st   = WALK_L1;
                    walk_d.sent = 1'b0;
                    walk_d.wr   = req_write;
                    walk_d.va   = req_vaddr;
                    walk_d.addr = l1_addr;
                    walk_d.pa   = '0;
                    walk_d.flt  = FLT_NONE;
                end
            end
            WALK_L1: begin
                walk_d.sent = 1'b1;
                if (walk_q.sent && mem_rsp_valid) begin
                    if (!ent_present) begin
                        walk_d.st  = WALK_DONE;
                        walk_d.flt = FLT_L1_ABSENT;
                    end else if (!ent_allowed) begin
                        walk_d.st  = WALK_DONE;
                        walk_d.flt = FLT_ACCESS;
                    end else begin
                        walk_d.st   = WALK_L2;
                        walk_d.sent = 1'b0;
                        walk_d.addr = l2_addr;
                    end
                end
            end
            WALK_L2: begin
                walk_d.sent = 1'b1;
                if (walk_q.sent && mem_rsp_valid) begin
                    walk_d.st = WALK_DONE;
                    if (!ent_present) begin
                        walk_d.flt = FLT_L2_ABSENT;
                    end else if (!ent_allowed) begin
                        walk_d.flt = FLT_ACCESS;
                    end else begin
                        walk_d.pa = {ent_ppn, walk_q.va[OFF_W-1:0]};
                    end
                end
            end
            WALK_DONE: begin
                if (rsp_ready) begin
                    walk_d.st = WALK_IDLE;
                end
            end
            default: walk_d.st = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '{st: WALK_IDLE, sent: 1'b0, wr: 1'b0, va: '0,
                        addr: '0, pa: '0, flt: FLT_NONE};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready   = (walk_q.st == WALK_IDLE);
    assign mem_rd_req  = ((walk_q.st == WALK_L1) || (walk_q.st == WALK_L2)) && !walk_q.sent;
    assign mem_rd_addr = walk_q.addr;
    assign rsp_valid   = (walk_q.st == WALK_DONE);
    assign rsp_paddr   = walk_q.pa;
    assign rsp_fault   = walk_q.flt;
    assign held_va     = walk_q.va;
    assign held_write  = walk_q.wr;

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    a_r9_wait_for_data: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_q.st != WALK_IDLE && walk_q.st != WALK_DONE && !mem_rsp_valid) |=> !rsp_valid);

    a_r6_stop_at_directory: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_q.st == WALK_L1 && walk_q.sent && mem_rsp_valid && !ent_present)
        |=> (rsp_valid && rsp_fault == 2'd1 && !mem_rd_req));

    a_r11_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int          VA_W      = 32,
    parameter int          PA_W      = 32,
    parameter int          PTE_W     = 32,
    parameter int          IDX_W     = 10,
    parameter int          OFF_W     = 12,
    parameter int          ENT_LOG2  = 2,
    parameter logic [31:0] ROOT_INIT = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              ctx_load,
    input  logic [PA_W-1:0]   ctx_root,
    output logic              mem_rd_req,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault
);
    localparam int PPN_W = PA_W - OFF_W;

    logic [PA_W-1:0]  root_d, root_q;
    logic [PA_W-1:0]  l1_addr, l2_addr;
    logic             ent_present, ent_allowed;
    logic [PPN_W-1:0] ent_ppn;
    logic [VA_W-1:0]  held_va;
    logic             held_write;

    // R10: table base register
    always_comb begin
        root_d = root_q;
        if (ctx_load) begin
            root_d = ctx_root;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            root_q <= PA_W'(ROOT_INIT);
        end else begin
            root_q <= root_d;
        end
    end

    a_r10_root_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_load |=> $stable(root_q));

    ptw_addr_gen #(
        .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENT_LOG2(ENT_LOG2)
    ) u_addr_gen (
        .dir_idx   (req_vaddr[VA_W-1 -: IDX_W]),
        .leaf_idx  (held_va[OFF_W +: IDX_W]),
        .root      (root_q),
        .table_ppn (ent_ppn),
        .l1_addr   (l1_addr),
        .l2_addr   (l2_addr)
    );

    ptw_entry_check #(
        .PTE_W(PTE_W), .PA_W(PA_W), .OFF_W(OFF_W)
    ) u_entry_check (
        .entry    (mem_rsp_data),
        .is_write (held_write),
        .present  (ent_present),
        .allowed  (ent_allowed),
        .ppn      (ent_ppn)
    );

    ptw_ctrl #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .l1_addr       (l1_addr),
        .l2_addr       (l2_addr),
        .ent_present   (ent_present),
        .ent_allowed   (ent_allowed),
        .ent_ppn       (ent_ppn),
        .held_va       (held_va),
        .held_write    (held_write),
        .mem_rd_req    (mem_rd_req),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault)
    );

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        ctx_load = 1'b0;
    logic [31:0] ctx_root = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int checks = 0;
    int errors = 0;

    // memory model state
    logic [31:0] t_addr [16];
    logic [31:0] t_data [16];
    int          t_n = 0;
    logic [31:0] rd_log [4];
    int          rd_cnt = 0;
    int          mem_lat = 1;
    int          wait_cnt = 0;
    logic [31:0] pend_addr = '0;
    logic        stray_pending = 1'b0;

    always #4 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write),
        .ctx_load(ctx_load), .ctx_root(ctx_root),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    function automatic logic [31:0] lookup(input logic [31:0] a);
        for (int i = 0; i < t_n; i++) begin
            if (t_addr[i] == a) return t_data[i];
        end
        return 32'h0;
    endfunction

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        t_addr[t_n] = a;
        t_data[t_n] = d;
        t_n++;
    endtask

    // memory: one read at a time, response mem_lat cycles after the request is seen
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (wait_cnt > 0) begin
                wait_cnt--;
                if (wait_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = lookup(pend_addr);
                end
            end else if (stray_pending) begin
                stray_pending = 1'b0;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = 32'hFFFF_FFFF;
            end
            if (mem_rd_req) begin
                if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
                rd_cnt++;
                pend_addr = mem_rd_addr;
                wait_cnt  = mem_lat;
            end
        end
    end

    task automatic chk(input logic ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", what, act, exp);
        end
    endtask

    task automatic do_walk(input logic [31:0] va, input logic wr, input int lat,
                           input logic [31:0] exp_l1, input logic [31:0] exp_l2,
                           input int exp_reads, input logic [1:0] exp_flt,
                           input logic [31:0] exp_pa, input string tag);
        logic        busy_ok;
        logic [31:0] pa0;
        logic [1:0]  f0;
        int          n;
        mem_lat = lat;
        rd_cnt  = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {"R1 ready low after accept ", tag}, 32'(req_ready), 32'h0);
        busy_ok = 1'b1;
        n = 0;
        while (!rsp_valid && n < 300) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(rsp_valid == 1'b1, {"R9 response arrives ", tag}, 32'(rsp_valid), 32'h1);
        chk(busy_ok, {"R1 ready low during walk ", tag}, 32'(busy_ok), 32'h1);
        chk(rd_cnt == exp_reads, {"R9 memory read count ", tag}, 32'(rd_cnt), 32'(exp_reads));
        chk(rd_log[0] == exp_l1, {"R2 directory address ", tag}, rd_log[0], exp_l1);
        if (exp_reads > 1)
            chk(rd_log[1] == exp_l2, {"R3 leaf address ", tag}, rd_log[1], exp_l2);
        chk(rsp_fault == exp_flt, {"R4 fault code ", tag}, 32'(rsp_fault), 32'(exp_flt));
        if (exp_flt == 2'd0)
            chk(rsp_paddr == exp_pa, {"R5 physical address ", tag}, rsp_paddr, exp_pa);
        pa0 = rsp_paddr;
        f0  = rsp_fault;
        repeat (2) @(negedge clk);
        chk(rsp_valid && rsp_paddr == pa0 && rsp_fault == f0,
            {"R11 result held ", tag}, rsp_paddr, pa0);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, {"R1 ready after take ", tag},
            32'(req_ready), 32'h1);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R12 reset ready", 32'(req_ready), 32'h1);
        chk(rsp_valid == 1'b0, "R12 reset rsp_valid", 32'(rsp_valid), 32'h0);
        chk(mem_rd_req == 1'b0, "R12 reset mem_rd_req", 32'(mem_rd_req), 32'h0);
        // R10: base resets to 0, so VA 0 reads directory entry at 0 (absent)
        do_walk(32'h0000_0000, 1'b0, 2, 32'h0, 32'h0, 1, 2'd1, 32'h0, "R10 reset base");
    endtask

    task automatic load_root(input logic [31:0] r);
        @(negedge clk);
        ctx_root = r;
        ctx_load = 1'b1;
        @(negedge clk);
        ctx_load = 1'b0;
    endtask

    task automatic t_read_ok;
        do_walk(32'h0040_3ABC, 1'b0, 1, 32'h0001_0004, 32'h0002_000C, 2, 2'd0,
                32'h1234_5ABC, "R5 read ok");
    endtask

    task automatic t_write_ok;
        do_walk(32'h0040_4123, 1'b1, 5, 32'h0001_0004, 32'h0002_0010, 2, 2'd0,
                32'h0ABC_D123, "R5 write ok");
    endtask

    task automatic t_perm_leaf;
        do_walk(32'h0040_5FFF, 1'b1, 3, 32'h0001_0004, 32'h0002_0014, 2, 2'd3,
                32'h0, "R8 write to read-only leaf");
        do_walk(32'h0040_6000, 1'b0, 2, 32'h0001_0004, 32'h0002_0018, 2, 2'd3,
                32'h0, "R8 read of write-only leaf");
    endtask

    task automatic t_l1_absent;
        do_walk(32'hFFC0_0123, 1'b0, 4, 32'h0001_0FFC, 32'h0, 1, 2'd1, 32'h0,
                "R6 directory absent");
    endtask

    task automatic t_perm_dir;
        do_walk(32'h0080_0000, 1'b1, 2, 32'h0001_0008, 32'h0, 1, 2'd3, 32'h0,
                "R8 directory denies write");
    endtask

    task automatic t_l2_absent;
        do_walk(32'h0080_5000, 1'b0, 3, 32'h0001_0008, 32'h0003_0014, 2, 2'd2,
                32'h0, "R7 leaf absent with perms set");
    endtask

    task automatic t_stray;
        @(negedge clk);
        stray_pending = 1'b1;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_req == 1'b0,
            "R9 stray response ignored", 32'(rsp_valid), 32'h0);
        do_walk(32'h0040_3ABC, 1'b0, 2, 32'h0001_0004, 32'h0002_000C, 2, 2'd0,
                32'h1234_5ABC, "R9 walk after stray");
    endtask

    task automatic t_ctx;
        fork
            do_walk(32'h0040_3ABC, 1'b0, 6, 32'h0001_0004, 32'h0002_000C, 2, 2'd0,
                    32'h1234_5ABC, "R10 old base mid-walk");
            begin
                repeat (4) @(negedge clk);
                ctx_root = 32'h0005_0FFC;
                ctx_load = 1'b1;
                @(negedge clk);
                ctx_load = 1'b0;
            end
        join
        do_walk(32'h0040_0010, 1'b0, 2, 32'h0005_1000, 32'h0006_0000, 2, 2'd0,
                32'h0077_7010, "R10 new unaligned base");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        put(32'h0001_0004, 32'h0002_0007);
        put(32'h0002_000C, 32'h1234_5003);
        put(32'h0002_0010, 32'h0ABC_D007);
        put(32'h0002_0014, 32'h0044_4003);
        put(32'h0002_0018, 32'h0055_5005);
        put(32'h0001_0008, 32'h0003_0003);
        put(32'h0003_0014, 32'h0009_9006);
        put(32'h0005_1000, 32'h0006_0003);
        put(32'h0006_0000, 32'h0077_7003);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        load_root(32'h0001_0000);
        t_read_ok();
        t_write_ok();
        t_perm_leaf();
        t_l1_absent();
        t_perm_dir();
        t_l2_absent();
        t_stray();
        t_ctx();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule